// File: doc/BRIEF.md
# Rational Ratio Sample Strobe Generator

This block runs on a single fast clock and produces a one-cycle input-sample enable. Over time the enable fires at a fraction INCR/MOD of the clock rate. The default ratio is 33/490, which suits a 140 MHz converter clock fed by data arriving at 66/7 MHz. Downstream logic uses the enable to shift a new input sample into its delay line.

Alongside the enable, the block drives a phase index in the range 0 to MOD-1. A polyphase interpolator uses this index to pick its coefficient set, and every coefficient memory is addressed with it in the same cycle.

Internally the block keeps a modulo accumulator. Each cycle it adds INCR, and it folds the sum back below MOD whenever the sum reaches MOD. The modulus is an arbitrary integer, not a power of two, so the strobe pattern repeats exactly every MOD cycles and the long-term rate has no error. The spacing between strobes is uneven: each strobe lands within one clock of its ideal time.

A synchronous reset and a separate restart input both return the sequence to phase zero. This lets the input stream line up with the first coefficient set.

Top module: `rational_strobe_gen`

## Requirements
- R1: While `rst` is high at a rising edge, the next cycle shows `phase` = 0 and `sample_en` = 0.
- R2: Without reset or restart, `phase` moves each cycle from p to (p + INCR) mod MOD. With the defaults, the first values after reset are 0, 33, 66, ..., 462, then 5.
- R3: `sample_en` is 1 in exactly those cycles where the previous step wrapped, that is where the previous p satisfied p + INCR >= MOD. Outside reset and restart, this is the same as `phase` < INCR.
- R4: Any MOD consecutive cycles of free running contain exactly INCR enables. With the defaults, that is 33 in 490.
- R5: Two consecutive enables are either floor(MOD/INCR) or ceil(MOD/INCR) cycles apart. With the defaults, that is 14 or 15.
- R6: A high `restart` at a rising edge has the same effect as reset: the next cycle shows `phase` 0 and `sample_en` 0, and the sequence then repeats from the start.
- R7: `phase` is always less than MOD.
- R8: The `phase` sequence after reset is periodic with period MOD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sample clock |
| rst | input | 1 | Synchronous active-high reset |
| restart | input | 1 | Synchronous return to phase zero |
| sample_en | output | 1 | One-cycle input-sample enable, registered |
| phase | output | $clog2(MOD) | Coefficient phase index, registered |

## Verification
A wrong accumulator value appears on `phase` in the very next cycle. A wrong wrap decision shows up in two places: `sample_en` in the same cycle as the bad phase, and a count of enables that is off within one MOD-cycle window. An off-by-one in the wrap compare or the subtraction lasts longer. It shifts strobe spacing outside the two legal gaps within about fifteen cycles, and it breaks exact periodicity at the end of the first 490-cycle period.

// File: rtl/rss_pkg.sv
package rss_pkg;
  // Bit width able to hold values 0 .. n-1 (at least one bit).
  function automatic int unsigned width_for(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  // Shortest and longest spacing between wraps for a step/modulus pair.
  function automatic int unsigned gap_lo(input int unsigned step, input int unsigned modulus);
    return modulus / step;
  endfunction

  function automatic int unsigned gap_hi(input int unsigned step, input int unsigned modulus);
    return (modulus + step - 1) / step;
  endfunction
endpackage

// File: rtl/rss_step.sv
// Combinational modulo step: next = (acc + INCR) mod MOD, wrap flag on fold.
module rss_step #(
  parameter int unsigned INCR = 33,
  parameter int unsigned MOD  = 490,
  parameter int unsigned W    = 9
) (
  input  logic [W-1:0] acc_i,
  output logic [W-1:0] acc_next_o,
  output logic         wrap_o
);
  localparam logic [W:0] INC_V = (W+1)'(INCR);
  localparam logic [W:0] MOD_V = (W+1)'(MOD);

  logic [W:0] sum;
  logic [W:0] folded;

  always_comb begin
    sum        = {1'b0, acc_i} + INC_V;
    folded     = sum - MOD_V;
    wrap_o     = (sum >= MOD_V);
    acc_next_o = wrap_o ? folded[W-1:0] : sum[W-1:0];
  end
endmodule

// File: rtl/rss_state.sv
// Phase register and registered enable, with reset and restart.
module rss_state #(
  parameter int unsigned INCR = 33,
  parameter int unsigned MOD  = 490,
  parameter int unsigned W    = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         restart,
  input  logic [W-1:0] acc_next_i,
  input  logic         wrap_i,
  output logic [W-1:0] acc_o,
  output logic         en_o
);
  always_ff @(posedge clk) begin
    if (rst || restart) begin
      acc_o <= '0;
      en_o  <= 1'b0;
    end else begin
      acc_o <= acc_next_i;
      en_o  <= wrap_i;
    end
  end

  // R1 / R6: reset or restart leaves phase 0 and no enable
  a_r1_reset_zero: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) || $past(restart)) |-> (acc_o == '0 && !en_o));

  // R2: phase advances by INCR modulo MOD
  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(restart)) |->
      (32'(acc_o) == (32'($past(acc_o)) + INCR) % MOD));

  // R3: enable coincides with a folded phase
  a_r3_en_wrap: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(restart)) |-> (en_o == (32'(acc_o) < INCR)));

  // R7: phase never reaches the modulus
  a_r7_phase_range: assert property (@(posedge clk) disable iff (rst)
    32'(acc_o) < MOD);
endmodule

// File: rtl/rational_strobe_gen.sv
module rational_strobe_gen #(
  parameter int unsigned INCR = 33,
  parameter int unsigned MOD  = 490,
  localparam int unsigned PW  = rss_pkg::width_for(MOD)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  output logic          sample_en,
  output logic [PW-1:0] phase
);
  localparam int unsigned GAP_LO = rss_pkg::gap_lo(INCR, MOD);
  localparam int unsigned GAP_HI = rss_pkg::gap_hi(INCR, MOD);
  localparam int unsigned GW     = rss_pkg::width_for(GAP_HI + 2);
  localparam int unsigned WW     = rss_pkg::width_for(MOD);
  localparam int unsigned CW     = rss_pkg::width_for(INCR + 2);

  logic [PW-1:0] acc_next;
  logic          wrap;

  rss_step #(.INCR(INCR), .MOD(MOD), .W(PW)) u_step (
    .acc_i      (phase),
    .acc_next_o (acc_next),
    .wrap_o     (wrap)
  );

  rss_state #(.INCR(INCR), .MOD(MOD), .W(PW)) u_state (
    .clk        (clk),
    .rst        (rst),
    .restart    (restart),
    .acc_next_i (acc_next),
    .wrap_i     (wrap),
    .acc_o      (phase),
    .en_o       (sample_en)
  );

  // Monitoring counters for the spacing and window properties.
  logic [GW-1:0] gap_cnt;
  logic          seen_en;
  logic [WW-1:0] win_cnt;
  logic [CW-1:0] en_cnt;
  logic          primed;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      gap_cnt <= '0;
      seen_en <= 1'b0;
      win_cnt <= '0;
      en_cnt  <= '0;
      primed  <= 1'b0;
    end else begin
      if (sample_en) begin
        gap_cnt <= GW'(1);
        seen_en <= 1'b1;
      end else if (32'(gap_cnt) <= GAP_HI) begin
        gap_cnt <= gap_cnt + 1'b1;
      end
      if (!primed) begin
        primed <= 1'b1;
      end else if (32'(win_cnt) == MOD - 1) begin
        win_cnt <= '0;
        en_cnt  <= '0;
      end else begin
        win_cnt <= win_cnt + 1'b1;
        en_cnt  <= en_cnt + CW'(sample_en);
      end
    end
  end

  // R5: spacing between enables stays within one cycle of ideal
  a_r5_gap: assert property (@(posedge clk) disable iff (rst || restart)
    (sample_en && seen_en) |-> (32'(gap_cnt) >= GAP_LO && 32'(gap_cnt) <= GAP_HI));

  // R4: each full window of MOD cycles carries exactly INCR enables
  a_r4_window: assert property (@(posedge clk) disable iff (rst || restart)
    (primed && 32'(win_cnt) == MOD - 1) |-> (32'(en_cnt) + 32'(sample_en) == INCR));
endmodule

// File: tb/rational_strobe_gen_tb.sv
module rational_strobe_gen_tb;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int unsigned INCR = 33;
  localparam int unsigned MOD  = 490;
  localparam int unsigned PW   = $clog2(MOD);
  localparam int GLO = MOD / INCR;
  localparam int GHI = (MOD + INCR - 1) / INCR;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst = 1'b1;
  logic          restart = 1'b0;
  logic          sample_en;
  logic [PW-1:0] phase;

  rational_strobe_gen #(.INCR(INCR), .MOD(MOD)) u_dut (
    .clk(clk), .rst(rst), .restart(restart), .sample_en(sample_en), .phase(phase)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int m_acc   = 0;
  bit m_en    = 1'b0;
  int first_period [MOD];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // One clock with given controls; updates the bench model and compares outputs.
  task automatic tick(input bit r, input bit rs);
    string tag;
    rst = r;
    restart = rs;
    @(posedge clk);
    if (r || rs) begin
      m_acc = 0;
      m_en  = 1'b0;
    end else begin
      m_en  = (m_acc + INCR >= MOD);
      m_acc = m_en ? m_acc + INCR - MOD : m_acc + INCR;
    end
    #1;
    tag = r ? "R1" : (rs ? "R6" : "R2");
    check(int'(phase) == m_acc, tag, int'(phase), m_acc);
    check(sample_en == m_en, r ? "R1" : (rs ? "R6" : "R3"), int'(sample_en), int'(m_en));
    check(int'(phase) < MOD, "R7", int'(phase), MOD - 1);
  endtask

  initial begin
    int cnt = 0;
    int last = 0;
    void'($urandom(32'd1357));
    repeat (3) tick(1'b1, 1'b0);

    // Three free-running periods: window counts, spacing, periodicity
    for (int k = 1; k <= 3 * int'(MOD); k++) begin
      tick(1'b0, 1'b0);
      if (k <= int'(MOD)) first_period[k-1] = int'(phase);
      else check(int'(phase) == first_period[(k-1) % MOD], "R8", int'(phase), first_period[(k-1) % MOD]);
      if (sample_en) begin
        cnt++;
        if (last > 0) check((k - last) == GLO || (k - last) == GHI, "R5", k - last, GHI);
        last = k;
      end
      if (k % MOD == 0) begin
        check(cnt == int'(INCR), "R4", cnt, INCR);
        cnt = 0;
      end
    end

    // Directed: restart right after a strobe, then one step yields INCR
    while (!sample_en) tick(1'b0, 1'b0);
    tick(1'b0, 1'b1);
    tick(1'b0, 1'b0);
    check(int'(phase) == int'(INCR), "R6", int'(phase), INCR);

    // Directed: restart held two cycles, reset mid-stream
    tick(1'b0, 1'b1);
    tick(1'b0, 1'b1);
    repeat (20) tick(1'b0, 1'b0);
    tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
    check(int'(phase) == int'(INCR), "R1", int'(phase), INCR);

    // Random controls with occasional restart and reset
    for (int k = 0; k < 3000; k++) begin
      int unsigned rv = $urandom;
      tick((rv % 211) == 0, ((rv >> 8) % 53) == 0);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule